// File: doc/BRIEF.md
# Floating-Point Special-Operand Exception Resolver

This block sits in front of a floating-point arithmetic datapath. It looks at up to three 32-bit binary floating-point operands and an operation code. The operation is square root, add, subtract, multiply, divide or fused multiply-add. From these alone it decides whether the result is already fixed without doing any arithmetic. Each operand is sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes the block raises the invalid-operation flag and the divide-by-zero flag, and produces a forced result word.

The datapath uses the bypass output to choose between its own computed result and the forced word. When bypass is low, the forced word is zero and both flags are clear, so the arithmetic path owns the outcome. The block is purely combinational and holds no state. The operand widths are parameters, and the defaults give the 32-bit format.

Top module: `fpx_special_resolve`

## Requirements
- R1: The operation code decides which operands are read: 0 = square root uses a; 1 = add, 2 = subtract, 3 = multiply and 4 = divide use a and b; 5 = fused multiply-add (a*b+c) uses a, b and c. A NaN or infinity on an operand the operation does not use has no effect on any output.
- R2: An operand word with sign in bit 31, exponent bits 30:23 all ones, a nonzero fraction and fraction bit 22 clear is a signalling NaN. Such a NaN on any used operand raises `flag_invalid`.
- R3: When any used operand is a NaN, the result is the first NaN in the order a, b, c, with bit 22 forced to 1 and `res_bypass` high. When every NaN present is quiet (bit 22 set), `flag_invalid` stays low.
- R4: An invalid operation with no NaN input produces the result 0x7FC00000. Every time `flag_invalid` is high, the result is a NaN with bit 22 set.
- R5: For divide, a finite nonzero a (normal or subnormal) divided by a zero b raises `flag_divzero`. The result is then an infinity (exponent all ones, fraction zero) whose sign is the XOR of the two operand signs. No other operation raises `flag_divzero`.
- R6: Divide raises `flag_invalid` for 0/0 and for infinity/infinity. Multiply raises it for zero times infinity, in either order.
- R7: Add raises `flag_invalid` for two infinities of opposite sign. Subtract raises it for two infinities of equal sign, because the sign of b is inverted before the comparison.
- R8: Square root raises `flag_invalid` for a negative operand that is not a zero (subnormal, normal or infinity). The square root of -0 is left to the datapath.
- R9: Fused multiply-add raises `flag_invalid` when a*b is zero times infinity. It also raises it when the product is infinite and c is an infinity whose sign differs from a_sign XOR b_sign.
- R10: When there is no NaN, no invalid case and no division by zero, the block returns a signed infinity with bypass high in these cases: an infinite square-root operand, an infinite add or subtract operand, an infinite factor in a multiply or in the product of a fused multiply-add, an infinite addend of a fused multiply-add, and an infinite dividend over a non-infinite divisor.
- R11: In every other case `res_bypass` is low, the result is zero and both flags are low.
- R12: Operation codes 6 and 7 read no operand: all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (see R1) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Addend for fused multiply-add |
| res_bypass | output | 1 | Forced result is valid and replaces the datapath result |
| res_value | output | 32 | Forced result word |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_divzero | output | 1 | Divide-by-zero exception |

## Verification
Two functions can fire on the same input word: the invalid flag from a signalling NaN, and the propagation of a NaN payload. The same input also stresses the a-then-b-then-c priority. These are provoked by sweeping every operation against every combination of twelve representative operands. The set holds signed zeros, subnormals, normals, infinities, and quiet and signalling NaNs with nonzero payloads. A reference model in the bench, written from the requirements, gives the expected word and flags. A correct design must raise the flag and still return the quieted payload of the first used NaN, not the canonical NaN. It must also ignore NaNs on operands the operation does not read.

// File: rtl/fpx_pkg.sv
// Shared types for the special-operand resolver.
// Assumes: operation codes 6 and 7 are unused and read no operand.
package fpx_pkg;

    typedef enum logic [2:0] {
        OP_SQRT = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4,
        OP_FMA  = 3'd5
    } fpx_op_e;

    // One-hot class of an operand, plus its sign bit.
    typedef struct packed {
        logic sign;
        logic zero;
        logic subn;
        logic norm;
        logic inf;
        logic qnan;
        logic snan;
    } fpx_cls_t;

    localparam int NUM_OPND = 3;

endpackage

// File: rtl/fpx_classify.sv
// Sorts one floating-point word into zero, subnormal, normal, infinity,
// quiet NaN or signalling NaN. Assumes: the top fraction bit is the quiet bit.
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_in,
    output fpx_cls_t              cls_out
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones, exp_zero, frac_zero;

    assign exp_f  = word_in[W-2 -: EXP_W];
    assign frac_f = word_in[FRAC_W-1:0];

    // Derive the field summaries and the class bits.
    always_comb begin
        exp_ones        = &exp_f;
        exp_zero        = ~|exp_f;
        frac_zero       = ~|frac_f;
        cls_out.sign    = word_in[W-1];
        cls_out.zero    = exp_zero & frac_zero;
        cls_out.subn    = exp_zero & ~frac_zero;
        cls_out.norm    = ~exp_zero & ~exp_ones;
        cls_out.inf     = exp_ones & frac_zero;
        cls_out.qnan    = exp_ones & ~frac_zero & frac_f[FRAC_W-1];
        cls_out.snan    = exp_ones & ~frac_zero & ~frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/fpx_rules.sv
// Applies the per-operation exception rules to the operand classes.
// Assumes: classes are one-hot. Outputs are already prioritised:
// NaN over invalid over divide-by-zero over infinity.
module fpx_rules
    import fpx_pkg::*;
(
    input  fpx_op_e        op,
    input  fpx_cls_t       cls [NUM_OPND],
    output logic [NUM_OPND-1:0] nan_used,
    output logic           nv,
    output logic           dz,
    output logic           inf_hit,
    output logic           inf_sign
);
    logic [NUM_OPND-1:0] use_vec;
    logic [NUM_OPND-1:0] snan_used;
    logic                any_nan, inv_op, dz_op, inf_op, inf_sg;
    logic                b_eff, prod_zi, prod_inf, prod_sg;

    // Which operands the selected operation reads.
    always_comb begin
        unique case (op)
            OP_SQRT:                        use_vec = 3'b001;
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: use_vec = 3'b011;
            OP_FMA:                         use_vec = 3'b111;
            default:                        use_vec = 3'b000;
        endcase
    end

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_nan
        assign nan_used[i]  = use_vec[i] & (cls[i].qnan | cls[i].snan);
        assign snan_used[i] = use_vec[i] & cls[i].snan;
    end

    assign any_nan = |nan_used;

    // Per-operation invalid, divide-by-zero and infinity detection.
    always_comb begin
        b_eff    = cls[1].sign ^ (op == OP_SUB);
        prod_zi  = (cls[0].zero & cls[1].inf) | (cls[0].inf & cls[1].zero);
        prod_inf = (cls[0].inf | cls[1].inf) & ~prod_zi;
        prod_sg  = cls[0].sign ^ cls[1].sign;
        inv_op   = 1'b0;
        dz_op    = 1'b0;
        inf_op   = 1'b0;
        inf_sg   = 1'b0;
        unique case (op)
            OP_SQRT: begin
                inv_op = cls[0].sign & (cls[0].subn | cls[0].norm | cls[0].inf);
                inf_op = cls[0].inf;
                inf_sg = cls[0].sign;
            end
            OP_ADD, OP_SUB: begin
                inv_op = cls[0].inf & cls[1].inf & (cls[0].sign != b_eff);
                inf_op = cls[0].inf | cls[1].inf;
                inf_sg = cls[0].inf ? cls[0].sign : b_eff;
            end
            OP_MUL: begin
                inv_op = prod_zi;
                inf_op = cls[0].inf | cls[1].inf;
                inf_sg = prod_sg;
            end
            OP_DIV: begin
                inv_op = (cls[0].zero & cls[1].zero) | (cls[0].inf & cls[1].inf);
                dz_op  = (cls[0].subn | cls[0].norm) & cls[1].zero;
                inf_op = cls[0].inf & ~cls[1].inf;
                inf_sg = prod_sg;
            end
            OP_FMA: begin
                inv_op = prod_zi | (prod_inf & cls[2].inf & (prod_sg != cls[2].sign));
                inf_op = prod_inf | cls[2].inf;
                inf_sg = prod_inf ? prod_sg : cls[2].sign;
            end
            default: begin
                inv_op = 1'b0;
            end
        endcase
    end

    // Priority: NaN input suppresses operation rules; NV suppresses DZ and infinity.
    always_comb begin
        nv       = (|snan_used) | (inv_op & ~any_nan);
        dz       = dz_op & ~any_nan & ~nv;
        inf_hit  = inf_op & ~any_nan & ~nv & ~dz;
        inf_sign = dz ? prod_sg : inf_sg;
    end

endmodule

// File: rtl/fpx_result_mux.sv
// Builds the forced result word from the rule outcomes.
// Assumes: the nan_used bits are valid only for operands the operation reads.
module fpx_result_mux
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [NUM_OPND-1:0][EXP_W+FRAC_W:0] opnd,
    input  logic [NUM_OPND-1:0]                 nan_used,
    input  logic                                nv,
    input  logic                                dz,
    input  logic                                inf_hit,
    input  logic                                inf_sign,
    output logic                                bypass,
    output logic [EXP_W+FRAC_W:0]               result
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] nan_pick;

    // First used NaN in operand order, quieted.
    always_comb begin
        nan_pick = '0;
        for (int i = NUM_OPND - 1; i >= 0; i--) begin
            if (nan_used[i]) nan_pick = opnd[i] | QUIET_BIT;
        end
    end

    // Select the forced word by priority.
    always_comb begin
        bypass = (|nan_used) | nv | dz | inf_hit;
        if (|nan_used)        result = nan_pick;
        else if (nv)          result = CANON_NAN;
        else if (dz | inf_hit) result = {inf_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else                  result = '0;
    end

endmodule

// File: rtl/fpx_special_resolve.sv
// Top level: classifies the operands, applies the rules and drives the
// forced result with bypass and exception flags. Combinational.
module fpx_special_resolve
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [2:0]                op_sel,
    input  logic [EXP_W+FRAC_W:0]     opnd_a,
    input  logic [EXP_W+FRAC_W:0]     opnd_b,
    input  logic [EXP_W+FRAC_W:0]     opnd_c,
    output logic                      res_bypass,
    output logic [EXP_W+FRAC_W:0]     res_value,
    output logic                      flag_invalid,
    output logic                      flag_divzero
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [NUM_OPND-1:0][W-1:0] opnd_vec;
    fpx_cls_t                   cls [NUM_OPND];
    logic [NUM_OPND-1:0]        nan_used;
    logic                       inf_hit, inf_sign;

    assign opnd_vec = {opnd_c, opnd_b, opnd_a};

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_cls
        fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_in (opnd_vec[i]),
            .cls_out (cls[i])
        );
    end

    fpx_rules u_rules (
        .op       (fpx_op_e'(op_sel)),
        .cls      (cls),
        .nan_used (nan_used),
        .nv       (flag_invalid),
        .dz       (flag_divzero),
        .inf_hit  (inf_hit),
        .inf_sign (inf_sign)
    );

    fpx_result_mux #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mux (
        .opnd     (opnd_vec),
        .nan_used (nan_used),
        .nv       (flag_invalid),
        .dz       (flag_divzero),
        .inf_hit  (inf_hit),
        .inf_sign (inf_sign),
        .bypass   (res_bypass),
        .result   (res_value)
    );

endmodule

// File: rtl/fpx_special_resolve_chk.sv
// Checker bound to the resolver: relates flags and result at the ports.
// Assumes: combinational top; checks skip any cycle with unknown values.
module fpx_special_resolve_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [2:0]            op_sel,
    input logic [EXP_W+FRAC_W:0] opnd_a,
    input logic [EXP_W+FRAC_W:0] opnd_b,
    input logic [EXP_W+FRAC_W:0] opnd_c,
    input logic                  res_bypass,
    input logic [EXP_W+FRAC_W:0] res_value,
    input logic                  flag_invalid,
    input logic                  flag_divzero
);
    localparam int W = 1 + EXP_W + FRAC_W;

    function automatic logic is_nan(input logic [W-1:0] x);
        return (&x[W-2 -: EXP_W]) & (|x[FRAC_W-1:0]);
    endfunction

    function automatic logic is_inf(input logic [W-1:0] x);
        return (&x[W-2 -: EXP_W]) & ~(|x[FRAC_W-1:0]);
    endfunction

    logic known, nan_in, a_snan;

    // Summaries of the inputs seen by the checks.
    always_comb begin
        known  = !$isunknown({op_sel, opnd_a, opnd_b, opnd_c, res_bypass,
                              res_value, flag_invalid, flag_divzero});
        nan_in = (op_sel <= 3'd5 && is_nan(opnd_a))
               | (op_sel >= 3'd1 && op_sel <= 3'd5 && is_nan(opnd_b))
               | (op_sel == 3'd5 && is_nan(opnd_c));
        a_snan = is_nan(opnd_a) & ~opnd_a[FRAC_W-1];
    end

    // Port-level exception and result consistency checks.
    always_comb begin
        if (known) begin
            if (flag_invalid)
                AST_NV_QUIET_NAN: assert (res_bypass && is_nan(res_value) && res_value[FRAC_W-1]); // R4
            if (flag_divzero)
                AST_DZ_SIGNED_INF: assert (op_sel == 3'd4 && is_inf(res_value) && !flag_invalid
                                           && res_value[W-1] == (opnd_a[W-1] ^ opnd_b[W-1])); // R5
            if (nan_in)
                AST_NAN_PROPAGATES: assert (res_bypass && is_nan(res_value)); // R3
            if (op_sel <= 3'd5 && a_snan)
                AST_SNAN_RAISES_NV: assert (flag_invalid); // R2
            if (!res_bypass)
                AST_IDLE_QUIET: assert (res_value == '0 && !flag_invalid && !flag_divzero); // R11
            if (op_sel > 3'd5)
                AST_BAD_OP_IDLE: assert (!res_bypass); // R12
        end
    end

endmodule

bind fpx_special_resolve fpx_special_resolve_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .op_sel       (op_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .opnd_c       (opnd_c),
    .res_bypass   (res_bypass),
    .res_value    (res_value),
    .flag_invalid (flag_invalid),
    .flag_divzero (flag_divzero)
);

// File: tb/fpx_special_resolve_test.sv
// Bench: directed cases per requirement, then a sweep of all operation codes
// over twelve representative operands per input, against a reference model.
module fpx_special_resolve_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        res_bypass, flag_invalid, flag_divzero;
    logic [31:0] res_value;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fpx_special_resolve uut (
        .op_sel       (op_sel),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .opnd_c       (opnd_c),
        .res_bypass   (res_bypass),
        .res_value    (res_value),
        .flag_invalid (flag_invalid),
        .flag_divzero (flag_divzero)
    );

    function automatic logic f_nan(input logic [31:0] x);
        return (&x[30:23]) && (|x[22:0]);
    endfunction
    function automatic logic f_snan(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic logic f_inf(input logic [31:0] x);
        return (&x[30:23]) && !(|x[22:0]);
    endfunction
    function automatic logic f_zero(input logic [31:0] x);
        return x[30:0] == 31'd0;
    endfunction
    function automatic logic f_finnz(input logic [31:0] x);
        return !(&x[30:23]) && !f_zero(x);
    endfunction

    function automatic logic [31:0] rep(input int k);
        case (k)
            0: return 32'h00000000;  1: return 32'h80000000;
            2: return 32'h00000001;  3: return 32'h80400000;
            4: return 32'h3F800000;  5: return 32'hC0490FDB;
            6: return 32'h7F800000;  7: return 32'hFF800000;
            8: return 32'h7FC00000;  9: return 32'hFFC12345;
            10: return 32'h7F800001; default: return 32'hFF812345;
        endcase
    endfunction

    // Reference model: returns {bypass, nv, dz, result}; tag names the deciding rule.
    function automatic logic [34:0] ref_out(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c,
                                            output int tag);
        int nu;
        logic na, nb, nc, sn, inv, dz, inf, sg, ps, pz, pinf, eb;
        nu = (op == 3'd0) ? 1 : (op <= 3'd4) ? 2 : (op == 3'd5) ? 3 : 0;
        tag = 11;
        if (nu == 0) begin tag = 12; return '0; end
        na = f_nan(a);
        nb = (nu >= 2) && f_nan(b);
        nc = (nu == 3) && f_nan(c);
        sn = f_snan(a) || (nu >= 2 && f_snan(b)) || (nu == 3 && f_snan(c));
        if (na || nb || nc) begin
            tag = sn ? 2 : 3;
            return {1'b1, sn, 1'b0, (na ? a : nb ? b : c) | 32'h00400000};
        end
        inv = 0; dz = 0; inf = 0; sg = 0;
        ps = a[31] ^ b[31];
        pz = (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
        case (op)
            3'd0: begin
                inv = a[31] && !f_zero(a); tag = inv ? 8 : 10;
                inf = f_inf(a); sg = a[31];
            end
            3'd1, 3'd2: begin
                eb = b[31] ^ (op == 3'd2);
                inv = f_inf(a) && f_inf(b) && (a[31] != eb); tag = inv ? 7 : 10;
                inf = f_inf(a) || f_inf(b); sg = f_inf(a) ? a[31] : eb;
            end
            3'd3: begin
                inv = pz; tag = inv ? 6 : 10;
                inf = f_inf(a) || f_inf(b); sg = ps;
            end
            3'd4: begin
                inv = (f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b)); tag = inv ? 6 : 5;
                dz = f_finnz(a) && f_zero(b);
                inf = f_inf(a) && !f_inf(b); sg = ps;
                if (!inv && !dz) tag = 10;
            end
            default: begin
                pinf = (f_inf(a) || f_inf(b)) && !pz;
                inv = pz || (pinf && f_inf(c) && ps != c[31]); tag = inv ? 9 : 10;
                inf = pinf || f_inf(c); sg = pinf ? ps : c[31];
            end
        endcase
        if (inv) return {1'b1, 1'b1, 1'b0, 32'h7FC00000};
        if (dz)  return {1'b1, 1'b0, 1'b1, ps, 8'hFF, 23'd0};
        if (inf) return {1'b1, 1'b0, 1'b0, sg, 8'hFF, 23'd0};
        tag = 11;
        return '0;
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge and sample one time unit later.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; opnd_c = c;
        #1;
    endtask

    task automatic directed(input string req, input logic [2:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] c, input logic byp,
                            input logic [31:0] res, input logic nv, input logic dz);
        apply(op, a, b, c);
        cmp(req, "bypass", {31'd0, res_bypass}, {31'd0, byp});
        cmp(req, "result", res_value, res);
        cmp(req, "invalid", {31'd0, flag_invalid}, {31'd0, nv});
        cmp(req, "divzero", {31'd0, flag_divzero}, {31'd0, dz});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: add of two zeros, nothing forced (R11)
        directed("R11", 3'd1, 0, 0, 0, 0, 0, 0, 0);
        // R1: unused operands ignored
        directed("R1", 3'd0, 32'h3F800000, 32'h7F800001, 32'h7F800001, 0, 0, 0, 0);
        directed("R1", 3'd1, 32'h3F800000, 32'h3F800000, 32'hFF812345, 0, 0, 0, 0);
        // R2: signalling NaN on b
        directed("R2", 3'd3, 32'h3F800000, 32'hFF812345, 0, 1, 32'hFFC12345, 1, 0);
        directed("R2", 3'd4, 32'h7F800001, 32'h7FC00005, 0, 1, 32'h7FC00001, 1, 0);
        // R3: quiet propagation and priority
        directed("R3", 3'd1, 32'h7FC00001, 32'hFFC00002, 0, 1, 32'h7FC00001, 0, 0);
        directed("R3", 3'd5, 32'h3F800000, 32'h7FC00003, 32'h7FC00004, 1, 32'h7FC00003, 0, 0);
        // R4, R6: 0/0 gives canonical NaN
        directed("R4", 3'd4, 0, 32'h80000000, 0, 1, 32'h7FC00000, 1, 0);
        // R5: divide by zero, signed
        directed("R5", 3'd4, 32'hC0000000, 32'h00000000, 0, 1, 32'hFF800000, 0, 1);
        directed("R5", 3'd4, 32'h80000001, 32'h80000000, 0, 1, 32'h7F800000, 0, 1);
        // R6: zero times infinity
        directed("R6", 3'd3, 32'h80000000, 32'h7F800000, 0, 1, 32'h7FC00000, 1, 0);
        directed("R6", 3'd4, 32'hFF800000, 32'h7F800000, 0, 1, 32'h7FC00000, 1, 0);
        // R7: infinities with effective opposite signs
        directed("R7", 3'd2, 32'h7F800000, 32'h7F800000, 0, 1, 32'h7FC00000, 1, 0);
        directed("R7", 3'd1, 32'h7F800000, 32'h7F800000, 0, 1, 32'h7F800000, 0, 0);
        // R8: negative square root
        directed("R8", 3'd0, 32'h80000001, 0, 0, 1, 32'h7FC00000, 1, 0);
        directed("R8", 3'd0, 32'h80000000, 0, 0, 0, 0, 0, 0);
        // R9: fused multiply-add infinite product versus addend
        directed("R9", 3'd5, 32'hFF800000, 32'h3F800000, 32'h7F800000, 1, 32'h7FC00000, 1, 0);
        directed("R9", 3'd5, 32'h00000000, 32'h7F800000, 32'h3F800000, 1, 32'h7FC00000, 1, 0);
        // R10: resolvable infinities
        directed("R10", 3'd5, 32'hFF800000, 32'h3F800000, 32'hFF800000, 1, 32'hFF800000, 0, 0);
        directed("R10", 3'd3, 32'h7F800000, 32'hBF800000, 0, 1, 32'hFF800000, 0, 0);
        directed("R10", 3'd2, 32'h3F800000, 32'h7F800000, 0, 1, 32'hFF800000, 0, 0);
        // R12: unused codes
        directed("R12", 3'd6, 32'h7F800001, 32'h7F800001, 32'h7F800001, 0, 0, 0, 0);
        directed("R12", 3'd7, 32'hFF800000, 0, 0, 0, 0, 0, 0);
        // Sweep: every code against all operand classes
        for (int op = 0; op < 8; op++) begin
            for (int ia = 0; ia < 12; ia++) begin
                for (int ib = 0; ib < 12; ib++) begin
                    for (int ic = 0; ic < 12; ic++) begin
                        int          tg;
                        logic [34:0] e;
                        string       rq;
                        e = ref_out(3'(op), rep(ia), rep(ib), rep(ic), tg);
                        rq = $sformatf("R%0d", tg);
                        apply(3'(op), rep(ia), rep(ib), rep(ic));
                        cmp(rq, "sweep bypass", {31'd0, res_bypass}, {31'd0, e[34]});
                        cmp(rq, "sweep invalid", {31'd0, flag_invalid}, {31'd0, e[33]});
                        cmp(rq, "sweep divzero", {31'd0, flag_divzero}, {31'd0, e[32]});
                        cmp(rq, "sweep result", res_value, e[31:0]);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule